// File: doc/BRIEF.md
# Mesh Sweep Sequencer with Vertex Write-Out

This block drives a programmable vertex core across every point of a two-dimensional mesh. Software writes a destination base address and the last column and last row indices, then sets the start bit. The block walks the mesh row by row. For each point it hands the column and row to the core with a one-cycle load pulse, which also clears the core's program counter. It then keeps the core running until the core reports a vector-output instruction.

When the core reports a vector output, the two 32-bit operands it supplies are sent out as two word writes over a valid/ready port, with each word in big-endian byte order. The target address of a point depends on its column and row with a fixed row pitch. A per-point instruction budget acts as a watchdog. When the budget runs out, the point is dropped, a sticky fault bit is set, and the sweep moves on. When the last point is done, the block holds the number of points visited and raises a single-cycle interrupt.

Top module: `mesh_sweep`

## Requirements
- R1: Writing register 0 with bit 0 set while idle starts a sweep. Register 0 bit 0 reads 1 from the next cycle until the sweep ends. A start written while a sweep runs is ignored and does not cause a second sweep.
- R2: Points are visited with the row index (0 to the last row, inclusive) in the outer loop and the column index (0 to the last column, inclusive) in the inner loop. Each point begins with a one-cycle `pointLoad` that carries `pointX`/`pointY`. `coreRun` is high from the next cycle until the core reports a vector output or the watchdog fires.
- R3: The first write of a point goes to base + 8 × (128 × y + x). Register 1 holds the base, register 2 the last column and register 3 the last row.
- R4: The first write carries operand A and the second carries operand B, at the first address + 4. Each data word is byte-reversed: operand bits 7:0 appear on `memData` bits 31:24.
- R5: Once `memValid` is high, it stays high, with `memAddr` and `memData` unchanged, until a cycle in which `memReady` is high.
- R6: Register 5 holds the address of the second word of the most recently completed write pair.
- R7: If a point sees 2048 `coreStep` cycles without a vector output, it is abandoned after exactly 2048 steps and issues no writes. Register 0 bit 1 is set and stays set until the next start. The sweep then continues with the next point.
- R8: When the sweep ends, register 4 holds (last column + 1) × (last row + 1). `sweepIrq` is high for exactly one cycle, and register 0 bit 0 reads 0 from the following cycle.
- R9: After reset, all readable registers read 0, and `memValid`, `coreRun`, `pointLoad` and `sweepIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index (0 control, 1 base, 2 last column, 3 last row, 4 vertex count, 5 last write address) |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data for `cfgAddr`, combinational |
| pointLoad | output | 1 | One-cycle pulse: load coordinates, clear program counter |
| pointX | output | 7 | Column of the current point |
| pointY | output | 7 | Row of the current point |
| coreRun | output | 1 | Core may execute instructions |
| coreStep | input | 1 | Core retired a non-output instruction this cycle |
| coreVecOut | input | 1 | Core executed the vector-output instruction this cycle |
| vecA | input | 32 | First output operand, valid with `coreVecOut` |
| vecB | input | 32 | Second output operand, valid with `coreVecOut` |
| memValid | output | 1 | Write request valid |
| memReady | input | 1 | Memory accepts the write |
| memAddr | output | 32 | Write byte address |
| memData | output | 32 | Write data, big-endian |
| sweepIrq | output | 1 | One-cycle end-of-sweep interrupt |

## Verification
The assertions check the cycle-level rules on every cycle. They cover the hold of address, data and valid under back-pressure, the +4 step from the first word to the second, the load pulse being followed by run, the single-cycle interrupt with busy dropped after it, and the watchdog counter staying inside its budget. Only the bench scenarios can show the rest. That includes the visiting order over a whole mesh, the address formula at the last column of the row pitch, the byte order, the final vertex count and last-address values, and the exact 2048-step abandonment of a hung point. The scenarios also show that a start written mid-sweep leaves the sweep unchanged.

// File: rtl/mesh_sweep_pkg.sv
package mesh_sweep_pkg;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_BASE  = 3'd1;
  localparam logic [2:0] REG_XLAST = 3'd2;
  localparam logic [2:0] REG_YLAST = 3'd3;
  localparam logic [2:0] REG_VERTS = 3'd4;
  localparam logic [2:0] REG_LASTA = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RUN, ST_WR0, ST_WR1, ST_NEXT, ST_DONE
  } sweep_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sweepBegin;
    logic pointClear;
    logic stepCount;
    logic vecLatch;
    logic selSecond;
    logic pairDone;
    logic faultSet;
    logic pointAdvance;
  } sweep_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic startReq;
    logic lastCol;
    logic lastRow;
    logic wdExpire;
  } sweep_sts_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/mesh_sweep_ctrl.sv
module mesh_sweep_ctrl
  import mesh_sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sweep_sts_t sts,
  input  logic       coreStep,
  input  logic       coreVecOut,
  input  logic       memReady,
  output sweep_ctl_t ctl,
  output logic       busy,
  output logic       pointLoad,
  output logic       coreRun,
  output logic       memValid,
  output logic       sweepIrq
);

  sweep_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (sts.startReq) begin
        ctl.sweepBegin = 1'b1;
        stateNext      = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.pointClear = 1'b1;
        stateNext      = ST_RUN;
      end
      ST_RUN: begin
        ctl.stepCount = coreStep && !coreVecOut;
        if (coreVecOut) begin
          ctl.vecLatch = 1'b1;
          stateNext    = ST_WR0;
        end else if (sts.wdExpire) begin
          ctl.faultSet = 1'b1;
          stateNext    = ST_NEXT;
        end
      end
      ST_WR0: if (memReady) stateNext = ST_WR1;
      ST_WR1: begin
        ctl.selSecond = 1'b1;
        if (memReady) begin
          ctl.pairDone = 1'b1;
          stateNext    = ST_NEXT;
        end
      end
      ST_NEXT: begin
        ctl.pointAdvance = 1'b1;
        stateNext = (sts.lastCol && sts.lastRow) ? ST_DONE : ST_LOAD;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign pointLoad = (state == ST_LOAD);
  assign coreRun   = (state == ST_RUN);
  assign memValid  = (state == ST_WR0) || (state == ST_WR1);
  assign sweepIrq  = (state == ST_DONE);

  a_r5_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);

  a_r2_load_then_run: assert property (@(posedge clk) disable iff (!rstN)
    pointLoad |=> coreRun);

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    sweepIrq |=> (!sweepIrq && !busy));

endmodule

// File: rtl/mesh_sweep_dp.sv
module mesh_sweep_dp
  import mesh_sweep_pkg::*;
#(
  parameter int ROW_PITCH  = 128,
  parameter int ROW_W      = 7,
  parameter int INSN_LIMIT = 2048,
  localparam int COL_W = $clog2(ROW_PITCH),
  localparam int WD_W  = $clog2(INSN_LIMIT + 1),
  localparam int CNT_W = COL_W + ROW_W + 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  sweep_ctl_t       ctl,
  input  logic             busy,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgAddr,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  input  logic [31:0]      vecA,
  input  logic [31:0]      vecB,
  output sweep_sts_t       sts,
  output logic [COL_W-1:0] pointX,
  output logic [ROW_W-1:0] pointY,
  output logic [31:0]      memAddr,
  output logic [31:0]      memData
);

  logic [31:0]      meshBase, lastAddr, opA, opB;
  logic [COL_W-1:0] colLast, curX;
  logic [ROW_W-1:0] rowLast, curY;
  logic [WD_W-1:0]  wdCnt;
  logic [CNT_W-1:0] vertCnt;
  logic             fault;
  logic             wdLast;
  logic [31:0]      pointAddr;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      meshBase <= '0;
      colLast  <= '0;
      rowLast  <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        REG_BASE:  meshBase <= cfgWrData;
        REG_XLAST: colLast  <= cfgWrData[COL_W-1:0];
        REG_YLAST: rowLast  <= cfgWrData[ROW_W-1:0];
        default: ;
      endcase
    end
  end

  // mesh position
  always_ff @(posedge clk) begin
    if (!rstN || ctl.sweepBegin) begin
      curX    <= '0;
      curY    <= '0;
      vertCnt <= '0;
    end else if (ctl.pointAdvance) begin
      vertCnt <= vertCnt + 1'b1;
      if (sts.lastCol) begin
        curX <= '0;
        curY <= sts.lastRow ? '0 : curY + 1'b1;
      end else begin
        curX <= curX + 1'b1;
      end
    end
  end

  // per-point instruction watchdog
  assign wdLast = (wdCnt == WD_W'(INSN_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN || ctl.pointClear) wdCnt <= '0;
    else if (ctl.stepCount && !wdLast) wdCnt <= wdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.sweepBegin) fault <= 1'b0;
    else if (ctl.faultSet)       fault <= 1'b1;
  end

  // operand capture and write-out
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA <= '0;
      opB <= '0;
    end else if (ctl.vecLatch) begin
      opA <= vecA;
      opB <= vecB;
    end
  end

  assign pointAddr = meshBase + (32'({curY, curX}) << 3);

  always_ff @(posedge clk) begin
    if (!rstN)             lastAddr <= '0;
    else if (ctl.pairDone) lastAddr <= memAddr;
  end

  assign memAddr = ctl.selSecond ? pointAddr + 32'd4 : pointAddr;
  assign memData = swapBytes(ctl.selSecond ? opB : opA);

  // status and readback
  assign sts.startReq = cfgWrEn && (cfgAddr == REG_CTRL) && cfgWrData[0];
  assign sts.lastCol  = (curX == colLast);
  assign sts.lastRow  = (curY == rowLast);
  assign sts.wdExpire = ctl.stepCount && wdLast;

  always_comb begin
    unique case (cfgAddr)
      REG_CTRL:  cfgRdData = {30'd0, fault, busy};
      REG_BASE:  cfgRdData = meshBase;
      REG_XLAST: cfgRdData = 32'(colLast);
      REG_YLAST: cfgRdData = 32'(rowLast);
      REG_VERTS: cfgRdData = 32'(vertCnt);
      REG_LASTA: cfgRdData = lastAddr;
      default:   cfgRdData = '0;
    endcase
  end

  assign pointX = curX;
  assign pointY = curY;

  a_r7_wd_bound: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt < WD_W'(INSN_LIMIT));

endmodule

// File: rtl/mesh_sweep.sv
module mesh_sweep
  import mesh_sweep_pkg::*;
#(
  parameter int ROW_PITCH  = 128,
  parameter int ROW_W      = 7,
  parameter int INSN_LIMIT = 2048,
  localparam int COL_W = $clog2(ROW_PITCH)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgAddr,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  output logic             pointLoad,
  output logic [COL_W-1:0] pointX,
  output logic [ROW_W-1:0] pointY,
  output logic             coreRun,
  input  logic             coreStep,
  input  logic             coreVecOut,
  input  logic [31:0]      vecA,
  input  logic [31:0]      vecB,
  output logic             memValid,
  input  logic             memReady,
  output logic [31:0]      memAddr,
  output logic [31:0]      memData,
  output logic             sweepIrq
);

  sweep_ctl_t ctl;
  sweep_sts_t sts;
  logic       busy;

  mesh_sweep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sts(sts), .coreStep(coreStep),
    .coreVecOut(coreVecOut), .memReady(memReady), .ctl(ctl), .busy(busy),
    .pointLoad(pointLoad), .coreRun(coreRun), .memValid(memValid),
    .sweepIrq(sweepIrq)
  );

  mesh_sweep_dp #(
    .ROW_PITCH(ROW_PITCH), .ROW_W(ROW_W), .INSN_LIMIT(INSN_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .vecA(vecA), .vecB(vecB), .sts(sts), .pointX(pointX), .pointY(pointY),
    .memAddr(memAddr), .memData(memData)
  );

  a_r5_payload_held: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memData)));

  a_r4_second_word_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(memValid && memReady)) |-> (memAddr == $past(memAddr) + 32'd4));

endmodule

// File: tb/test_mesh_sweep.sv
`timescale 1ns/1ps
module test_mesh_sweep;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic pointLoad, coreRun, memValid, sweepIrq;
  logic [6:0] pointX, pointY;
  logic coreStep = 1'b0, coreVecOut = 1'b0, memReady = 1'b0;
  logic [31:0] vecA = '0, vecB = '0, memAddr, memData;

  always #2.5 clk = ~clk;

  mesh_sweep i_mesh_sweep (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .pointLoad(pointLoad),
    .pointX(pointX), .pointY(pointY), .coreRun(coreRun), .coreStep(coreStep),
    .coreVecOut(coreVecOut), .vecA(vecA), .vecB(vecB), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData), .sweepIrq(sweepIrq)
  );

  int nChecks = 0, nFails = 0;
  int pointsSeen = 0, wordsSeen = 0, irqCount = 0, hangSteps = 0;
  int expX = 0, expY = 0, cfgCols = 0, stallMode = 0, stallCtr = 0;
  int curPX = 0, curPY = 0, stepsLeft = 0;
  bit hangEn = 0;
  int hangX = 0, hangY = 0;
  logic [31:0] cfgBase = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] opA(input int x, input int y);
    return {8'h12, 8'(y), 8'h5A, 8'(x)};
  endfunction
  function automatic logic [31:0] opB(input int x, input int y);
    return {8'(x), 8'hC3, 8'(y), 8'h9E};
  endfunction
  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // core model
  initial forever begin
    @(negedge clk);
    coreStep = 1'b0;
    coreVecOut = 1'b0;
    if (pointLoad) begin
      check(pointX == 7'(expX) && pointY == 7'(expY), "R2 order",
            {pointY, 9'd0, pointX}, {7'(expY), 9'd0, 7'(expX)});
      curPX = int'(pointX);
      curPY = int'(pointY);
      pointsSeen++;
      stepsLeft = 3;
      expX++;
      if (expX > cfgCols) begin expX = 0; expY++; end
    end else if (coreRun) begin
      if (hangEn && curPX == hangX && curPY == hangY) begin
        coreStep = 1'b1;
        hangSteps++;
      end else if (stepsLeft > 0) begin
        coreStep = 1'b1;
        stepsLeft--;
      end else begin
        coreVecOut = 1'b1;
        vecA = opA(curPX, curPY);
        vecB = opB(curPX, curPY);
      end
    end
  end

  // memory model with optional back-pressure
  initial forever begin
    @(negedge clk);
    memReady = 1'b0;
    if (memValid) begin
      stallCtr++;
      if (stallMode == 0 || stallCtr % 3 == 0) begin
        logic [31:0] ea, ed;
        ea = cfgBase + 32'((curPY * 128 + curPX) * 8) + ((wordsSeen % 2 == 1) ? 32'd4 : 32'd0);
        ed = rev((wordsSeen % 2 == 1) ? opB(curPX, curPY) : opA(curPX, curPY));
        memReady = 1'b1;
        check(memAddr == ea, "R3/R4 address", memAddr, ea);
        check(memData == ed, "R4 data order", memData, ed);
        wordsSeen++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (sweepIrq) irqCount++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfgAddr = a;
    #0.5;
    d = cfgRdData;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (sweepIrq) begin seen = 1; break; end
    end
  endtask

  task automatic setup(input logic [31:0] base, input int cl, input int rl, input int stall);
    cfgBase = base; cfgCols = cl; stallMode = stall;
    expX = 0; expY = 0; pointsSeen = 0; wordsSeen = 0; irqCount = 0;
    wr(3'd1, base);
    wr(3'd2, 32'(cl));
    wr(3'd3, 32'(rl));
  endtask

  task automatic finish_checks(input int cl, input int rl, input logic [31:0] expLast, input int pairs, input bit expFault);
    logic [31:0] v;
    bit seen;
    wait_irq(seen);
    check(seen, "R8 irq raised", 32'(seen), 32'd1);
    rd(3'd4, v);
    check(v == 32'((cl + 1) * (rl + 1)), "R8 vertex count", v, 32'((cl + 1) * (rl + 1)));
    rd(3'd5, v);
    check(v == expLast, "R6 last address", v, expLast);
    @(negedge clk);
    check(!sweepIrq, "R8 irq one cycle", 32'(sweepIrq), 32'd0);
    rd(3'd0, v);
    check(v[0] == 1'b0, "R8 busy cleared", v, 32'd0);
    check(v[1] == expFault, "R7 fault flag", v, 32'(expFault) << 1);
    check(pointsSeen == (cl + 1) * (rl + 1), "R2 points visited", 32'(pointsSeen), 32'((cl + 1) * (rl + 1)));
    check(wordsSeen == 2 * pairs, "R4 words written", 32'(wordsSeen), 32'(2 * pairs));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check(v == 32'd0, "R9 reset register", v, 32'd0);
    end
    check(!memValid && !coreRun && !pointLoad && !sweepIrq, "R9 reset outputs",
          {28'd0, memValid, coreRun, pointLoad, sweepIrq}, 32'd0);
  endtask

  task automatic t_sweep(input logic [31:0] base, input int cl, input int rl, input int stall);
    setup(base, cl, rl, stall);
    wr(3'd0, 32'd1);
    finish_checks(cl, rl, base + 32'((rl * 128 + cl) * 8 + 4), (cl + 1) * (rl + 1), 1'b0);
  endtask

  task automatic t_busy_restart();
    logic [31:0] v;
    setup(32'h0004_0000, 2, 1, 1);
    wr(3'd0, 32'd1);
    rd(3'd0, v);
    check(v[0] == 1'b1, "R1 busy reads one", v, 32'd1);
    repeat (4) @(negedge clk);
    wr(3'd0, 32'd1);
    finish_checks(2, 1, 32'h0004_0000 + 32'((128 + 2) * 8 + 4), 6, 1'b0);
    repeat (30) @(negedge clk);
    check(pointsSeen == 6 && irqCount == 1, "R1 start while busy ignored",
          32'(pointsSeen), 32'd6);
  endtask

  task automatic t_timeout();
    setup(32'h0010_0000, 1, 1, 0);
    hangEn = 1; hangX = 1; hangY = 1; hangSteps = 0;
    wr(3'd0, 32'd1);
    finish_checks(1, 1, 32'h0010_0000 + 32'(128 * 8 + 4), 3, 1'b1);
    check(hangSteps == 2048, "R7 abandon after limit", 32'(hangSteps), 32'd2048);
    hangEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep(32'h8000_0000, 0, 0, 0);
    t_sweep(32'h0000_1000, 3, 2, 1);
    t_sweep(32'h0020_0000, 127, 1, 0);
    t_busy_restart();
    t_timeout();
    t_sweep(32'h0000_0040, 1, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #900000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule